// File: doc/BRIEF.md
# Counter Access Enable Checker

This block owns three 32-bit control registers for the user-visible counter window: a machine-level counter enable, a supervisor-level counter enable and a machine-level counter inhibit. The three registers share one write port. Each write is legalized against a writable-counter mask that the platform supplies. The block decides whether a CSR access may go ahead when it is aimed at one of the 32 user counter addresses, 0xC00 through 0xC1F, at the current privilege level. A trap unit upstream uses the allow flag. The counter datapath uses the inhibit bits.

The allow decision is combinational. Its inputs are the address, the privilege level, the supervisor-present flag and the registers as they are now. Addresses outside the counter window always pass. Inside the window, the low five address bits pick one bit from each enable register, and the privilege level decides which of those bits count.

Top module: `cnt_access_gate`

## Requirements
- R1: After reset all three registers (machine enable, supervisor enable, inhibit) read zero.
- R2: An address below 0xC00 or above 0xC1F drives accessOk high at every privilege level and for any register contents.
- R3: With privLvl = 2'b11 (machine), accessOk is high for every address.
- R4: With privLvl = 2'b01 (supervisor) and an address in 0xC00..0xC1F, accessOk equals bit addr[4:0] of the machine enable register.
- R5: With privLvl = 2'b00 (user), or the reserved code 2'b10 (treated as user), and an address in 0xC00..0xC1F, accessOk is high only when bit addr[4:0] of the machine enable register is set. It also needs the same bit of the supervisor enable register to be set when supImpl is high.
- R6: A write with wrSel = 0 (machine enable) or wrSel = 1 (supervisor enable) stores wrData[31:0] AND {writableMask[31:3], 3'b111}. Bits of wrData above bit 31 have no effect.
- R7: A write with wrSel = 2 (inhibit) stores wrData[31:0] AND {writableMask[31:3], 3'b101}, so inhibit bit 1 always reads zero.
- R8: When wrEn is low, or when wrSel = 3, none of the three registers changes.
- R9: A write takes effect at the clock edge where wrEn is sampled high. From that edge on, accessOk follows the new value with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrAddr | input | 12 | CSR address being accessed |
| privLvl | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 treated as user |
| supImpl | input | 1 | Supervisor mode is implemented |
| writableMask | input | 32 | Platform mask of implemented counters; bits 2..0 unused |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 machine enable, 1 supervisor enable, 2 inhibit, 3 none |
| wrData | input | 64 | Write value; only bits 31..0 are used |
| accessOk | output | 1 | Access is permitted |
| mEnable | output | 32 | Legalized machine counter enable |
| sEnable | output | 32 | Legalized supervisor counter enable |
| inhibit | output | 32 | Per-counter inhibit bits |

## Verification
The assertions assume that privLvl, csrAddr and the write inputs are steady and known around each rising edge. They also assume that writableMask holds its value during the cycle of a write, because each legalization check compares the stored register with the mask sampled at that write. The bench changes every input only on the falling edge, so these assumptions hold. Random stimulus covers all four privilege codes and all four wrSel codes, including the reserved privilege code and the no-target select. Half of the addresses are drawn inside the counter window and half anywhere in the 12-bit space. Both supImpl settings are exercised.

// File: rtl/cnt_gate_pkg.sv
package cnt_gate_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } privT;

  localparam int REG_NUM = 3;
  localparam int SEL_MEN = 0;
  localparam int SEL_SEN = 1;
  localparam int SEL_INH = 2;

  typedef struct packed {
    logic [REG_NUM-1:0] wrStb;
  } ctrlStbT;

endpackage

// File: rtl/cnt_gate_ctrl.sv
module cnt_gate_ctrl
  import cnt_gate_pkg::*;
#(
  parameter int CNT_NUM  = 32,
  parameter int ADDR_W   = 12,
  parameter logic [11:0] CNT_BASE = 12'hC00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   csrAddr,
  input  logic [1:0]          privLvl,
  input  logic                supImpl,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [CNT_NUM-1:0]  mEnable,
  input  logic [CNT_NUM-1:0]  sEnable,
  output ctrlStbT             stb,
  output logic                accessOk
);
  localparam int IDX_W = $clog2(CNT_NUM);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(CNT_BASE + CNT_NUM - 1);

  privT             privCur;
  logic             inWindow;
  logic [IDX_W-1:0] cntIdx;
  logic             mBit;
  logic             sBit;

  assign privCur  = privT'(privLvl);
  assign inWindow = (csrAddr >= LO_ADDR) && (csrAddr <= HI_ADDR);
  assign cntIdx   = csrAddr[IDX_W-1:0];
  assign mBit     = mEnable[cntIdx];
  assign sBit     = sEnable[cntIdx];

  always_comb begin
    stb.wrStb = '0;
    if (wrEn) begin
      case (wrSel)
        2'd0:    stb.wrStb[SEL_MEN] = 1'b1;
        2'd1:    stb.wrStb[SEL_SEN] = 1'b1;
        2'd2:    stb.wrStb[SEL_INH] = 1'b1;
        default: stb.wrStb = '0;
      endcase
    end
  end

  always_comb begin
    if (!inWindow) begin
      accessOk = 1'b1;
    end else begin
      case (privCur)
        PRIV_MACH:  accessOk = 1'b1;
        PRIV_SUPER: accessOk = mBit;
        default:    accessOk = mBit && (!supImpl || sBit);
      endcase
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.wrStb)); // R8

  AST_OUTSIDE_OK: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr < LO_ADDR || csrAddr > HI_ADDR) |-> accessOk); // R2

  AST_MACH_OK: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl == 2'b11) |-> accessOk); // R3

  AST_NO_MEN_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (inWindow && privLvl != 2'b11 && !mEnable[csrAddr[IDX_W-1:0]]) |-> !accessOk); // R4

endmodule

// File: rtl/cnt_gate_dp.sv
module cnt_gate_dp
  import cnt_gate_pkg::*;
#(
  parameter int CNT_NUM = 32,
  parameter int XLEN    = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStbT            stb,
  input  logic [CNT_NUM-1:0] writableMask,
  input  logic [XLEN-1:0]    wrData,
  output logic [CNT_NUM-1:0] mEnable,
  output logic [CNT_NUM-1:0] sEnable,
  output logic [CNT_NUM-1:0] inhibit
);
  logic [CNT_NUM-1:0] regQ [REG_NUM];
  logic [CNT_NUM-1:0] wrLow;

  assign wrLow = wrData[CNT_NUM-1:0];

  for (genvar g = 0; g < REG_NUM; g++) begin : gReg
    logic [2:0]         fixedLow;
    logic [CNT_NUM-1:0] legalMask;

    assign fixedLow  = (g == SEL_INH) ? 3'b101 : 3'b111;
    assign legalMask = {writableMask[CNT_NUM-1:3], fixedLow};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              regQ[g] <= '0;
      else if (stb.wrStb[g])  regQ[g] <= wrLow & legalMask;
    end

    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      !stb.wrStb[g] |=> $stable(regQ[g])); // R8
  end

  assign mEnable = regQ[SEL_MEN];
  assign sEnable = regQ[SEL_SEN];
  assign inhibit = regQ[SEL_INH];

  AST_MEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb[SEL_MEN] |=> mEnable == ($past(wrData[CNT_NUM-1:0]) &
                                       {$past(writableMask[CNT_NUM-1:3]), 3'b111})); // R6

  AST_INH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb[SEL_INH] |=> inhibit == ($past(wrData[CNT_NUM-1:0]) &
                                       {$past(writableMask[CNT_NUM-1:3]), 3'b101})); // R7

  AST_TIMER_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    !inhibit[1]); // R7

endmodule

// File: rtl/cnt_access_gate.sv
module cnt_access_gate
  import cnt_gate_pkg::*;
#(
  parameter int CNT_NUM = 32,
  parameter int XLEN    = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  csrAddr,
  input  logic [1:0]         privLvl,
  input  logic               supImpl,
  input  logic [CNT_NUM-1:0] writableMask,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [XLEN-1:0]    wrData,
  output logic               accessOk,
  output logic [CNT_NUM-1:0] mEnable,
  output logic [CNT_NUM-1:0] sEnable,
  output logic [CNT_NUM-1:0] inhibit
);
  ctrlStbT stb;

  cnt_gate_ctrl #(.CNT_NUM(CNT_NUM), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .privLvl(privLvl),
    .supImpl(supImpl), .wrEn(wrEn), .wrSel(wrSel),
    .mEnable(mEnable), .sEnable(sEnable), .stb(stb), .accessOk(accessOk)
  );

  cnt_gate_dp #(.CNT_NUM(CNT_NUM), .XLEN(XLEN)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .writableMask(writableMask),
    .wrData(wrData), .mEnable(mEnable), .sEnable(sEnable), .inhibit(inhibit)
  );

endmodule

// File: tb/sim_cnt_access_gate.sv
module sim_cnt_access_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  privLvl = '0;
  logic        supImpl = 1'b0;
  logic [31:0] writableMask = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [63:0] wrData = '0;
  logic        accessOk;
  logic [31:0] mEnable, sEnable, inhibit;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  logic [31:0] mdlM = '0, mdlS = '0, mdlI = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_access_gate u0 (.*);

  function automatic bit expAllow(logic [11:0] a, logic [1:0] p, logic sup,
                                  logic [31:0] me, logic [31:0] se);
    if (a < 12'hC00 || a > 12'hC1F) return 1'b1;
    if (p == 2'b11) return 1'b1;
    if (p == 2'b01) return me[a[4:0]];
    return me[a[4:0]] && (!sup || se[a[4:0]]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(bit we, logic [1:0] sel, logic [63:0] d, logic [31:0] msk,
                      logic [11:0] a, logic [1:0] p, bit sup, string req);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; writableMask = msk;
    csrAddr = a; privLvl = p; supImpl = sup;
    #1;
    chk({req, " allow"}, 32'(accessOk), 32'(expAllow(a, p, sup, mdlM, mdlS)));
    @(posedge clk);
    if (we) begin
      case (sel)
        2'd0: mdlM = d[31:0] & {msk[31:3], 3'b111};
        2'd1: mdlS = d[31:0] & {msk[31:3], 3'b111};
        2'd2: mdlI = d[31:0] & {msk[31:3], 3'b101};
        default: ;
      endcase
    end
    #1;
    chk({req, " mEnable"}, mEnable, mdlM);
    chk({req, " sEnable"}, sEnable, mdlS);
    chk({req, " inhibit"}, inhibit, mdlI);
    // R9: allow follows the new contents right after the edge
    chk("R9 post-edge allow", 32'(accessOk), 32'(expAllow(a, p, sup, mdlM, mdlS)));
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mEnable reset", mEnable, 32'h0);
    chk("R1 sEnable reset", sEnable, 32'h0);
    chk("R1 inhibit reset", inhibit, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2/R3/R5 with cleared enables
    doOp(0, 2'd0, '0, '0, 12'hBFF, 2'b00, 1, "R2 below window");
    doOp(0, 2'd0, '0, '0, 12'hC20, 2'b00, 1, "R2 above window");
    doOp(0, 2'd0, '0, '0, 12'hC05, 2'b11, 1, "R3 machine");
    doOp(0, 2'd0, '0, '0, 12'hC00, 2'b00, 0, "R5 user denied");
    // R6: zero mask keeps low three bits only; upper wrData ignored
    doOp(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 12'hC02, 2'b01, 1, "R6 zero mask");
    doOp(1, 2'd0, 64'hFFFF_FFFF_0000_0000, 32'hFFFF_FFFF, 12'hC02, 2'b01, 1, "R6 upper ignored");
    // R7: inhibit timer bit forced to zero
    doOp(1, 2'd2, 64'hFFFF_FFFF, 32'hFFFF_FFFF, 12'h300, 2'b11, 1, "R7 inhibit all");
    // R8: wrSel 3 and wrEn low change nothing
    doOp(1, 2'd3, 64'hFFFF_FFFF, 32'hFFFF_FFFF, 12'hC1F, 2'b00, 1, "R8 sel3");
    doOp(0, 2'd1, 64'hFFFF_FFFF, 32'hFFFF_FFFF, 12'hC1F, 2'b00, 1, "R8 wrEn low");
    // R4/R5 with machine bit set, supervisor bit clear
    doOp(1, 2'd0, 64'h8000_0010, 32'hFFFF_FFFF, 12'hC1F, 2'b01, 1, "R4 set m bit");
    doOp(0, 2'd0, '0, 32'hFFFF_FFFF, 12'hC1F, 2'b01, 1, "R4 super allowed");
    doOp(0, 2'd0, '0, 32'hFFFF_FFFF, 12'hC1F, 2'b00, 1, "R5 user needs s bit");
    doOp(0, 2'd0, '0, 32'hFFFF_FFFF, 12'hC1F, 2'b10, 0, "R5 reserved no super");
    doOp(1, 2'd1, 64'h8000_0000, 32'hFFFF_FFFF, 12'hC1F, 2'b00, 1, "R5 set s bit");

    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      a = ($urandom % 2) ? {7'b1100000, 5'($urandom)} : 12'($urandom);
      doOp(($urandom % 3) != 0, 2'($urandom), {$urandom, $urandom}, $urandom,
           a, 2'($urandom), 1'($urandom), "R4/R5/R6/R7 random");
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule